// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block decides when a small processor-style core may drop into its deepest low-power standby state, and how it comes back out. It watches the core's wait-for-interrupt, wait-for-event and return-from-handler strobes. An entry is granted only when the required control bits and flags all hold in the same cycle. A granted entry raises a standby request, which the power logic around the block uses to remove power from the core domain.

Standby always ends in a reset phase. The wake sources are:
- a rising edge on the wake pin;
- any RTC status flag;
- an external reset request;
- a watchdog reset request.

When one of them arrives, the block raises a fixed-length domain reset pulse and then returns to run. A standby flag survives that domain reset, so software can tell after boot that the chip came back from standby. A watchdog-running indication is also modelled. Once started, it runs through standby, and only a reset stops it.

Top module: `stby_ctrl`

## Requirements
- R1: A wait-for-interrupt strobe moves the block from run to standby on the next clock edge, with `stby_req` high from then on, when all of the following hold in the strobe cycle: `deep_sleep`=1, `pdown_sel`=1, `wake_flag`=0, `irq_pending`=0, and the RTC flag chosen by `rtc_sel` is 0.
- R2: A wait-for-event strobe enters standby under the same control and flag conditions, except that it is blocked by `evt_pending`=1 and is not affected by `irq_pending`.
- R3: A return-from-handler strobe enters standby only when `sleep_on_exit`=1, in addition to the wait-for-interrupt conditions of R1. With `sleep_on_exit`=0 it has no effect.
- R4: If any required condition fails, the strobe is refused and `stby_req` stays 0. Each of the following refuses entry: `deep_sleep`=0, `pdown_sel`=0, `wake_flag`=1, the selected RTC flag set, or the relevant pending indicator set.
- R5: In standby, a low-to-high change on `wake_pin` starts the wake reset, and `dom_rst` rises 3 clock edges after the change. A pin that is already high when standby is entered does not wake the block.
- R6: In standby, any of the following makes `dom_rst` rise on the next edge, with `stby_req` falling at the same edge: any bit of `rtc_flags` at 1, `ext_rst_req`=1, or `wdg_rst_req`=1. The bits of `rtc_flags` are: 0 = alarm A, 1 = alarm B, 2 = periodic wakeup, 3 = tamper, 4 = timestamp.
- R7: `dom_rst` stays high for exactly RST_CYCLES (default 4) cycles, with `stby_req` low during that time. The block then sits in run. Entry strobes seen while `dom_rst` is high are ignored.
- R8: `stby_flag` is set on the edge where `dom_rst` rises. It is held through the domain reset and cleared by a one-cycle `flag_clr` strobe. A set and a clear in the same cycle leave the flag set. The power-on reset `rst_n` clears it.
- R9: `wdg_active` becomes 1 on the edge after a `wdg_start` strobe and stays 1 through standby. It is cleared only by `dom_rst` or by `rst_n`.
- R10: An `rtc_sel` value of NUM_RTC or more refuses every entry. The value is the index of the RTC flag bit, as listed in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wfi_strobe | input | 1 | One-cycle wait-for-interrupt strobe |
| wfe_strobe | input | 1 | One-cycle wait-for-event strobe |
| isr_ret_strobe | input | 1 | One-cycle return-from-handler strobe |
| deep_sleep | input | 1 | Deep-sleep control bit |
| sleep_on_exit | input | 1 | Sleep-on-exit control bit |
| pdown_sel | input | 1 | Power-down select: standby instead of stop |
| irq_pending | input | 1 | An interrupt is pending |
| evt_pending | input | 1 | An event is pending |
| wake_flag | input | 1 | Wakeup flag still set |
| rtc_flags | input | NUM_RTC | RTC status flags, bit order as in R6 |
| rtc_sel | input | RTC_SEL_W | Index of the RTC flag that must be clear for entry |
| wake_pin | input | 1 | Asynchronous wake pin |
| ext_rst_req | input | 1 | External reset-pin request |
| wdg_rst_req | input | 1 | Watchdog reset request |
| wdg_start | input | 1 | One-cycle watchdog start strobe |
| flag_clr | input | 1 | Write-one-to-clear strobe for the standby flag |
| stby_req | output | 1 | Standby request, high only in standby |
| dom_rst | output | 1 | Domain reset pulse raised on wakeup |
| stby_flag | output | 1 | Preserved standby flag |
| wdg_active | output | 1 | Watchdog running indication |

## Verification
The assertions assume the following about the inputs:
- Every input except `wake_pin` is synchronous to `clk`.
- The strobes are single-cycle.
- A wake source seen in standby is the only thing that can end standby.

The wake-pin edge is internal to the synchronizer, so the properties check the port-level wake sources directly. The pin path and its three-edge latency are left to the directed tests. The bench changes every input on the falling clock edge and drops each strobe after one cycle. It also clears each RTC flag and reset request before the next entry, so a refusal is never confused with an immediate wake.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_STBY = 2'd1,
      ST_WAKE = 2'd2
   } stby_state_e;
endpackage

// File: rtl/stby_edge.sv
module stby_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/stby_gate.sv
module stby_gate #(
   parameter int NUM_RTC   = 5,
   parameter int RTC_SEL_W = 3
) (
   input  logic                 wfi_strobe,
   input  logic                 wfe_strobe,
   input  logic                 isr_ret_strobe,
   input  logic                 deep_sleep,
   input  logic                 sleep_on_exit,
   input  logic                 pdown_sel,
   input  logic                 irq_pending,
   input  logic                 evt_pending,
   input  logic                 wake_flag,
   input  logic [NUM_RTC-1:0]   rtc_flags,
   input  logic [RTC_SEL_W-1:0] rtc_sel,
   output logic                 enter
);
   logic sel_flag;
   logic base_ok;

   // an index past the flag vector counts as a set flag, so entry is refused
   always_comb begin
      sel_flag = 1'b1;
      for (int i = 0; i < NUM_RTC; i++) begin
         if (rtc_sel == RTC_SEL_W'(i)) sel_flag = rtc_flags[i];
      end
   end

   assign base_ok = deep_sleep & pdown_sel & ~wake_flag & ~sel_flag;

   assign enter = base_ok & ((wfi_strobe & ~irq_pending) |
                             (wfe_strobe & ~evt_pending) |
                             (isr_ret_strobe & sleep_on_exit & ~irq_pending));
endmodule

// File: rtl/stby_seq.sv
module stby_seq
   import stby_pkg::*;
#(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic wake,
   output logic in_stby,
   output logic in_wake,
   output logic wake_hit
);
   localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

   stby_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_RUN:  if (enter) state_q <= ST_STBY;
            ST_STBY: if (wake) begin
               state_q <= ST_WAKE;
               cnt_q   <= '0;
            end
            ST_WAKE: begin
               if (cnt_q == CNT_LAST) state_q <= ST_RUN;
               else                   cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign in_stby  = (state_q == ST_STBY);
   assign in_wake  = (state_q == ST_WAKE);
   assign wake_hit = in_stby & wake;
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
   parameter int NUM_RTC     = 5,
   parameter int RTC_SEL_W   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYCLES  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wfi_strobe,
   input  logic                 wfe_strobe,
   input  logic                 isr_ret_strobe,
   input  logic                 deep_sleep,
   input  logic                 sleep_on_exit,
   input  logic                 pdown_sel,
   input  logic                 irq_pending,
   input  logic                 evt_pending,
   input  logic                 wake_flag,
   input  logic [NUM_RTC-1:0]   rtc_flags,
   input  logic [RTC_SEL_W-1:0] rtc_sel,
   input  logic                 wake_pin,
   input  logic                 ext_rst_req,
   input  logic                 wdg_rst_req,
   input  logic                 wdg_start,
   input  logic                 flag_clr,
   output logic                 stby_req,
   output logic                 dom_rst,
   output logic                 stby_flag,
   output logic                 wdg_active
);
   if (NUM_RTC < 1) begin : g_bad_rtc
      $error("NUM_RTC must be at least 1");
   end
   if ((2 ** RTC_SEL_W) < NUM_RTC) begin : g_bad_sel
      $error("RTC_SEL_W too narrow for NUM_RTC");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end

   logic pin_rise;
   logic enter;
   logic wake_any;
   logic wake_hit;
   logic flag_q;
   logic wdg_q;

   stby_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (wake_pin),
      .rise  (pin_rise)
   );

   stby_gate #(.NUM_RTC(NUM_RTC), .RTC_SEL_W(RTC_SEL_W)) u_gate (
      .wfi_strobe     (wfi_strobe),
      .wfe_strobe     (wfe_strobe),
      .isr_ret_strobe (isr_ret_strobe),
      .deep_sleep     (deep_sleep),
      .sleep_on_exit  (sleep_on_exit),
      .pdown_sel      (pdown_sel),
      .irq_pending    (irq_pending),
      .evt_pending    (evt_pending),
      .wake_flag      (wake_flag),
      .rtc_flags      (rtc_flags),
      .rtc_sel        (rtc_sel),
      .enter          (enter)
   );

   assign wake_any = pin_rise | (|rtc_flags) | ext_rst_req | wdg_rst_req;

   stby_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .enter    (enter),
      .wake     (wake_any),
      .in_stby  (stby_req),
      .in_wake  (dom_rst),
      .wake_hit (wake_hit)
   );

   // preserved flag: only the power-on reset clears it, set beats clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (wake_hit) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   // watchdog run indication: stopped only by a reset of either kind
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wdg_q <= 1'b0;
      else if (dom_rst)   wdg_q <= 1'b0;
      else if (wdg_start) wdg_q <= 1'b1;
   end

   assign stby_flag  = flag_q;
   assign wdg_active = wdg_q;
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
   parameter int NUM_RTC    = 5,
   parameter int RST_CYCLES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               deep_sleep,
   input logic               pdown_sel,
   input logic               wake_flag,
   input logic               irq_pending,
   input logic               wfe_strobe,
   input logic [NUM_RTC-1:0] rtc_flags,
   input logic               ext_rst_req,
   input logic               wdg_rst_req,
   input logic               flag_clr,
   input logic               stby_req,
   input logic               dom_rst,
   input logic               stby_flag,
   input logic               wdg_active
);
   localparam int RUN_W = $clog2(RST_CYCLES + 1) + 1;

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (dom_rst) run_q <= run_q + 1'b1;
      else              run_q <= '0;
   end

   AST_NO_ENTRY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (!stby_req && (!deep_sleep || !pdown_sel || wake_flag)) |=> !stby_req); // R4

   AST_NO_ENTRY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!stby_req && irq_pending && !wfe_strobe) |=> !stby_req); // R1

   AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_req && ((|rtc_flags) || ext_rst_req || wdg_rst_req)) |=> (dom_rst && !stby_req)); // R6

   AST_RST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      dom_rst |-> !stby_req); // R7

   AST_RST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      dom_rst |-> (run_q < RUN_W'(RST_CYCLES))); // R7

   AST_RST_LEN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_rst) |-> (run_q == RUN_W'(RST_CYCLES))); // R7

   AST_FLAG_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_rst) |-> stby_flag); // R8

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_flag && !flag_clr) |=> stby_flag); // R8

   AST_WDG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wdg_active && !dom_rst) |=> wdg_active); // R9
endmodule

bind stby_ctrl stby_ctrl_chk #(.NUM_RTC(NUM_RTC), .RST_CYCLES(RST_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .deep_sleep  (deep_sleep),
   .pdown_sel   (pdown_sel),
   .wake_flag   (wake_flag),
   .irq_pending (irq_pending),
   .wfe_strobe  (wfe_strobe),
   .rtc_flags   (rtc_flags),
   .ext_rst_req (ext_rst_req),
   .wdg_rst_req (wdg_rst_req),
   .flag_clr    (flag_clr),
   .stby_req    (stby_req),
   .dom_rst     (dom_rst),
   .stby_flag   (stby_flag),
   .wdg_active  (wdg_active)
);

// File: tb/stby_ctrl_bench.sv
`timescale 1ns/1ps
module stby_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wfi_strobe = 0, wfe_strobe = 0, isr_ret_strobe = 0;
   logic       deep_sleep = 0, sleep_on_exit = 0, pdown_sel = 0;
   logic       irq_pending = 0, evt_pending = 0, wake_flag = 0;
   logic [4:0] rtc_flags = '0;
   logic [2:0] rtc_sel = '0;
   logic       wake_pin = 0, ext_rst_req = 0, wdg_rst_req = 0;
   logic       wdg_start = 0, flag_clr = 0;
   logic       stby_req, dom_rst, stby_flag, wdg_active;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   stby_ctrl u_stby_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wfi_strobe(wfi_strobe), .wfe_strobe(wfe_strobe), .isr_ret_strobe(isr_ret_strobe),
      .deep_sleep(deep_sleep), .sleep_on_exit(sleep_on_exit), .pdown_sel(pdown_sel),
      .irq_pending(irq_pending), .evt_pending(evt_pending), .wake_flag(wake_flag),
      .rtc_flags(rtc_flags), .rtc_sel(rtc_sel), .wake_pin(wake_pin),
      .ext_rst_req(ext_rst_req), .wdg_rst_req(wdg_rst_req),
      .wdg_start(wdg_start), .flag_clr(flag_clr),
      .stby_req(stby_req), .dom_rst(dom_rst), .stby_flag(stby_flag), .wdg_active(wdg_active)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic allow_all();
      deep_sleep = 1; pdown_sel = 1; wake_flag = 0;
      irq_pending = 0; evt_pending = 0; sleep_on_exit = 0;
      rtc_flags = '0; rtc_sel = 3'd0;
   endtask

   task automatic pulse_wfi();
      wfi_strobe = 1; tick(); wfi_strobe = 0;
   endtask

   // wake by external request, then count the reset pulse length
   task automatic wake_ext(input string tag);
      int len;
      ext_rst_req = 1; tick(); ext_rst_req = 0;
      len = 0;
      while (dom_rst && len < 20) begin len++; tick(); end
      chk({tag, " reset length"}, len, 4);
      chk({tag, " run after reset"}, stby_req, 0);
   endtask

   task automatic t_reset();
      chk("R8 reset flag", stby_flag, 0);
      chk("R7 reset dom_rst", dom_rst, 0);
      chk("R1 reset stby_req", stby_req, 0);
      chk("R9 reset wdg", wdg_active, 0);
   endtask

   task automatic t_wfi();
      allow_all(); rtc_sel = 3'd2; rtc_flags = 5'b00001;
      pulse_wfi();
      chk("R1 wfi entry with unselected flag set", stby_req, 1);
      rtc_flags = '0;
      wake_ext("R7 wfi");
   endtask

   task automatic t_wfe();
      allow_all(); irq_pending = 1; evt_pending = 1;
      wfe_strobe = 1; tick(); wfe_strobe = 0;
      chk("R2 wfe refused on event", stby_req, 0);
      evt_pending = 0;
      wfe_strobe = 1; tick(); wfe_strobe = 0;
      chk("R2 wfe entry with irq pending", stby_req, 1);
      irq_pending = 0;
      wake_ext("R2 wfe");
   endtask

   task automatic t_ret();
      allow_all();
      isr_ret_strobe = 1; tick(); isr_ret_strobe = 0;
      chk("R3 return without sleep_on_exit", stby_req, 0);
      sleep_on_exit = 1; irq_pending = 1;
      isr_ret_strobe = 1; tick(); isr_ret_strobe = 0;
      chk("R3 return refused on irq", stby_req, 0);
      irq_pending = 0;
      isr_ret_strobe = 1; tick(); isr_ret_strobe = 0;
      chk("R3 return entry", stby_req, 1);
      wake_ext("R3 return");
   endtask

   task automatic t_refuse();
      allow_all(); deep_sleep = 0; pulse_wfi();
      chk("R4 no deep_sleep", stby_req, 0);
      allow_all(); pdown_sel = 0; pulse_wfi();
      chk("R4 no pdown_sel", stby_req, 0);
      allow_all(); wake_flag = 1; pulse_wfi();
      chk("R4 wake_flag set", stby_req, 0);
      allow_all(); rtc_sel = 3'd3; rtc_flags = 5'b01000; pulse_wfi();
      chk("R4 selected rtc flag", stby_req, 0);
      allow_all(); irq_pending = 1; pulse_wfi();
      chk("R4 wfi irq pending", stby_req, 0);
      allow_all(); rtc_sel = 3'd6; pulse_wfi();
      chk("R10 out of range select", stby_req, 0);
      allow_all(); rtc_sel = 3'd4; pulse_wfi();
      chk("R10 last valid select", stby_req, 1);
      wake_ext("R10");
   endtask

   task automatic t_pin();
      allow_all(); wake_pin = 1; tick(5);
      pulse_wfi();
      chk("R5 entry with pin high", stby_req, 1);
      tick(10);
      chk("R5 high level ignored", stby_req, 1);
      wake_pin = 0; tick(4);
      chk("R5 falling edge ignored", stby_req, 1);
      wake_pin = 1; tick(2);
      chk("R5 no wake before latency", dom_rst, 0);
      tick();
      chk("R5 wake after 3 edges", dom_rst, 1);
      chk("R8 flag set on pin wake", stby_flag, 1);
      tick(3);
      chk("R7 reset still high in cycle 4", dom_rst, 1);
      tick();
      chk("R7 reset low after 4", dom_rst, 0);
      wake_pin = 0;
   endtask

   task automatic t_sources();
      for (int b = 0; b < 5; b++) begin
         allow_all(); pulse_wfi();
         rtc_flags = 5'(1 << b); tick(); rtc_flags = '0;
         chk($sformatf("R6 rtc bit %0d wake", b), dom_rst, 1);
         tick(5);
      end
      allow_all(); pulse_wfi();
      wdg_rst_req = 1; tick(); wdg_rst_req = 0;
      chk("R6 watchdog request wake", dom_rst, 1);
      chk("R6 standby dropped", stby_req, 0);
      tick(5);
   endtask

   task automatic t_ignore();
      allow_all(); pulse_wfi();
      ext_rst_req = 1; tick(); ext_rst_req = 0;
      wfi_strobe = 1; tick(4); wfi_strobe = 0;
      tick(2);
      chk("R7 strobes during reset ignored", stby_req, 0);
   endtask

   task automatic t_flag();
      flag_clr = 1; tick(); flag_clr = 0;
      chk("R8 clear strobe", stby_flag, 0);
      allow_all(); pulse_wfi();
      ext_rst_req = 1; flag_clr = 1; tick(); ext_rst_req = 0; flag_clr = 0;
      chk("R8 set beats clear", stby_flag, 1);
      tick(6);
      chk("R8 kept through domain reset", stby_flag, 1);
   endtask

   task automatic t_wdg();
      wdg_start = 1; tick(); wdg_start = 0;
      chk("R9 start", wdg_active, 1);
      allow_all(); pulse_wfi(); tick(5);
      chk("R9 runs in standby", wdg_active, 1);
      ext_rst_req = 1; tick(); ext_rst_req = 0;
      tick(5);
      chk("R9 stopped by domain reset", wdg_active, 0);
      wdg_start = 1; tick(); wdg_start = 0;
      rst_n = 0; tick(); rst_n = 1; tick();
      chk("R9 stopped by power-on reset", wdg_active, 0);
      chk("R8 power-on reset clears flag", stby_flag, 0);
   endtask

   initial begin
      tick(3); rst_n = 1; tick();
      t_reset();
      t_wfi();
      t_wfe();
      t_ret();
      t_refuse();
      t_pin();
      t_sources();
      t_ignore();
      t_flag();
      t_wdg();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule